// File: doc/BRIEF.md
# RAM-Backed Fixed Delay Line

This block delays a stream of words by a fixed number of cycles. The samples are not pushed through a chain of flip-flops. Each sample is parked in a small two-port RAM: one port writes and the other reads. Two address counters step through the RAM, so the pointers move instead of the data. The delay equals the RAM depth, 2^ADDR_W entries.

In every enabled cycle, one new word is written and the oldest word is read out. When the enable is low, the line freezes: nothing is written, neither counter moves, and the output holds its value.

After a reset, the output is not meaningful until the line has been filled once. A valid flag rises at the moment the first real sample reaches the output.

Top module: `ram_delay_line`

## Requirements
- R1: With N = 2^ADDR_W, the word on `dout` after an enabled edge equals the word on `din` at the enabled edge N-1 enabled edges earlier. Equivalently, the delay is N enabled cycles.
- R2: While `rst` is high and until the first enabled edge after it, `dout` is all zeros and `dout_valid` is 0. The reset places the read address at entry 0 and the write address at entry N-1 (all ones).
- R3: At every edge outside reset, the write address is exactly one entry behind the read address, modulo N.
- R4: Each enabled edge advances the read address by one. After all ones it wraps to zero, and the delay of R1 keeps holding across any number of wraps.
- R5: An edge with `shift_en` low writes nothing and moves no address. `dout` and `dout_valid` keep their values, and such cycles do not count toward the delay.
- R6: `dout_valid` becomes 1 right after the N-th enabled edge following reset. It stays 1 until the next reset.
- R7: A reset in the middle of a stream restarts the line. `dout_valid` drops to 0, and the first word written after that reset is the first word flagged valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Enable; high means write one word and read one word this cycle |
| din | input | DATA_W | Word entering the delay line |
| dout | output | DATA_W | Word leaving the delay line, registered |
| dout_valid | output | 1 | High once the line has been filled since reset |

## Verification
Two things happen in every enabled cycle. The newest word is written one entry below the oldest word, and in the same cycle that oldest word is read out. At the wrap point, the write lands on the top entry while the read comes from entry zero. The bench keeps the enable high across more than two full turns of the RAM to provoke this case. It judges each output against a queue model that holds every word it has driven.

A second collision happens on the N-th enabled edge, where `dout_valid` rises and the first real word appears on `dout` together. The bench checks that both appear on that same edge. It provokes this after the first reset and again after a reset issued in mid-stream.

// File: rtl/ram_delay_line_pkg.sv
`timescale 1ns/1ps
package ram_delay_line_pkg;

    // Lifecycle of the line after reset.
    typedef enum logic {
        PH_FILLING = 1'b0,
        PH_STEADY  = 1'b1
    } line_phase_e;

    // Number of RAM entries for a given address width.
    function automatic int unsigned depth_of(input int unsigned aw);
        return 32'd1 << aw;
    endfunction

endpackage

// File: rtl/ram_delay_line_ptr.sv
`timescale 1ns/1ps
// Wrapping address counter with a selectable reset value.
module ram_delay_line_ptr #(
    parameter int unsigned ADDR_W   = 4,
    parameter bit          INIT_TOP = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] INIT_VAL = INIT_TOP ? {ADDR_W{1'b1}} : {ADDR_W{1'b0}};

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= INIT_VAL;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/ram_delay_line_mem.sv
`timescale 1ns/1ps
// Storage with one write port and one registered read port.
module ram_delay_line_mem #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    import ram_delay_line_pkg::*;

    localparam int unsigned DEPTH = depth_of(ADDR_W);

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= store[rd_addr];
        end
    end
endmodule

// File: rtl/ram_delay_line_fill.sv
`timescale 1ns/1ps
// Counts enabled cycles after reset until the line holds real data.
module ram_delay_line_fill #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic filled
);
    import ram_delay_line_pkg::*;

    localparam int unsigned  DEPTH = depth_of(ADDR_W);
    localparam logic [ADDR_W:0] LAST = (ADDR_W+1)'(DEPTH - 1);

    logic [ADDR_W:0] seen;
    line_phase_e     phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen  <= '0;
            phase <= PH_FILLING;
        end else if (step && (phase == PH_FILLING)) begin
            seen <= seen + 1'b1;
            if (seen == LAST) begin
                phase <= PH_STEADY;
            end
        end
    end

    assign filled = (phase == PH_STEADY);
endmodule

// File: rtl/ram_delay_line.sv
`timescale 1ns/1ps
// Fixed delay line of 2^ADDR_W cycles held in a two-port RAM.
module ram_delay_line #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid
);
    logic [ADDR_W-1:0] rd_ptr;
    logic [ADDR_W-1:0] wr_ptr;

    // Reader starts at entry 0, writer at the top entry: one entry apart.
    ram_delay_line_ptr #(.ADDR_W(ADDR_W), .INIT_TOP(1'b0)) rd_ctr_i (
        .clk (clk),
        .rst (rst),
        .step(shift_en),
        .ptr (rd_ptr)
    );

    ram_delay_line_ptr #(.ADDR_W(ADDR_W), .INIT_TOP(1'b1)) wr_ctr_i (
        .clk (clk),
        .rst (rst),
        .step(shift_en),
        .ptr (wr_ptr)
    );

    ram_delay_line_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (shift_en),
        .wr_addr(wr_ptr),
        .wr_data(din),
        .rd_en  (shift_en),
        .rd_addr(rd_ptr),
        .rd_data(dout)
    );

    ram_delay_line_fill #(.ADDR_W(ADDR_W)) fill_i (
        .clk   (clk),
        .rst   (rst),
        .step  (shift_en),
        .filled(dout_valid)
    );
endmodule

// File: rtl/ram_delay_line_chk.sv
`timescale 1ns/1ps
module ram_delay_line_chk #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              shift_en,
    input logic [ADDR_W-1:0] rd_ptr,
    input logic [ADDR_W-1:0] wr_ptr,
    input logic [DATA_W-1:0] dout,
    input logic              dout_valid
);
    localparam int unsigned DEPTH = 32'd1 << ADDR_W;

    // Independent count of enabled edges since reset, saturating at DEPTH.
    int unsigned en_seen;
    always_ff @(posedge clk) begin
        if (rst) begin
            en_seen <= 0;
        end else if (shift_en && (en_seen != DEPTH)) begin
            en_seen <= en_seen + 1;
        end
    end

    a_r2_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rd_ptr == '0) && (wr_ptr == '1) && !dout_valid && (dout == '0));

    a_r3_ptr_gap: assert property (@(posedge clk) disable iff (rst)
        (ADDR_W'(rd_ptr - wr_ptr) == ADDR_W'(1)));

    a_r4_rd_step: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (rd_ptr == ADDR_W'($past(rd_ptr) + 1'b1)));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(rd_ptr) && $stable(wr_ptr) && $stable(dout) && $stable(dout_valid));

    a_r6_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        dout_valid |=> dout_valid);

    a_r6_valid_timing: assert property (@(posedge clk) disable iff (rst)
        dout_valid == (en_seen == DEPTH));
endmodule

bind ram_delay_line ram_delay_line_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (shift_en),
    .rd_ptr    (rd_ptr),
    .wr_ptr    (wr_ptr),
    .dout      (dout),
    .dout_valid(dout_valid)
);

// File: tb/ram_delay_line_tb_top.sv
`timescale 1ns/1ps
module ram_delay_line_tb_top;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 8;
    localparam int          N      = 1 << ADDR_W;

    // Each entry: bit 8 = enable, bits 7:0 = input word.
    localparam logic [8:0] STIM [32] = '{
        9'h111, 9'h122, 9'h133, 9'h044, 9'h155, 9'h166, 9'h077, 9'h088,
        9'h199, 9'h1AA, 9'h1BB, 9'h1CC, 9'h0DD, 9'h1EE, 9'h1F0, 9'h101,
        9'h112, 9'h023, 9'h034, 9'h145, 9'h156, 9'h167, 9'h178, 9'h089,
        9'h19A, 9'h1AB, 9'h1BC, 9'h1CD, 9'h1DE, 9'h0EF, 9'h1FE, 9'h1ED
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              shift_en = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic              dout_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [DATA_W-1:0] hist [256];
    int                npush = 0;
    logic [DATA_W-1:0] exp_dout = '0;

    always #2.5 clk = ~clk;

    ram_delay_line #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .din       (din),
        .dout      (dout),
        .dout_valid(dout_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst = 1'b1;
        shift_en = 1'b0;
        repeat (cycles) @(posedge clk);
        #1;
        npush = 0;
        exp_dout = '0;
        chk(dout_valid == 1'b0, "R2 valid in reset", dout_valid, 0);
        chk(dout == '0, "R2 dout in reset", dout, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One cycle with the reference queue model.
    task automatic step(input logic e, input logic [DATA_W-1:0] d, input string req);
        logic exp_valid;
        @(negedge clk);
        shift_en = e;
        din = d;
        if (e) begin
            hist[npush] = d;
            npush++;
            if (npush >= N) exp_dout = hist[npush - N];
        end
        @(posedge clk);
        #1;
        exp_valid = (npush >= N);
        chk(dout_valid == exp_valid, {req, " R6 valid"}, dout_valid, exp_valid);
        if (exp_valid) chk(dout == exp_dout, {req, " R1 dout"}, dout, exp_dout);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset(3);
        // R2: state holds after reset while disabled (R5).
        step(1'b0, 8'h5A, "R5 idle");
        chk(dout == '0, "R2 dout before first enable", dout, 0);
        step(1'b0, 8'hA5, "R5 idle");

        // Table walked twice; second pass inverted. Covers R1, R4 wrap, R5 gaps, R6.
        for (int i = 0; i < 64; i++) begin
            logic [8:0] v;
            v = STIM[i % 32];
            step(v[8], (i >= 32) ? ~v[7:0] : v[7:0], (v[8] ? "R4 run" : "R5 gap"));
        end

        // R5: a run of idle cycles leaves dout and valid untouched.
        begin
            logic [DATA_W-1:0] held;
            held = dout;
            for (int i = 0; i < 3; i++) step(1'b0, 8'hC3, "R5 hold");
            chk(dout == held, "R5 dout held", dout, held);
        end

        // R7: mid-stream reset, refill, first valid word is first post-reset word.
        do_reset(2);
        for (int i = 0; i < N; i++) begin
            step(1'b1, 8'hA0 + 8'(i), "R7 refill");
            if (i == N - 2) chk(dout_valid == 1'b0, "R7 not yet valid", dout_valid, 0);
        end
        chk(dout == 8'hA0, "R7 first word", dout, 8'hA0);
        chk(dout_valid == 1'b1, "R6 valid after N", dout_valid, 1);

        // R4: long enabled run across several wraps.
        for (int i = 0; i < 3 * N; i++) step(1'b1, 8'(i * 7 + 3), "R4 wrap");

        finish_run();
    end
endmodule